// File: doc/BRIEF.md
# Dual-Port Interprocessor Mailbox

This block links two processors, called side A and side B, through a shared set of registers. Each side has its own simple 32-bit register port. Either side can ring doorbells toward its peer. The peer sees those doorbells as latched status bits, and it can acknowledge, mask and poll them. Each direction has a single interrupt line, and that line is raised while any unmasked doorbell is pending. A small bank of message words can be read and written from both ports. Either side can return the whole mailbox to its reset state through a self-clearing software reset bit.

Each direction carries 16 doorbells. They sit in a 16-bit window inside the 32-bit registers, and the window's bit offset is a parameter chosen per direction. A masked doorbell is still recorded in raw status, so firmware can mask everything at start-up and poll or acknowledge the bits later.

Port register map, the same for both ports, with word-aligned byte addresses:

| Address | Name | Access |
|---|---|---|
| 0x00 | CTRL | bit 0 is the software reset; it reads back as 1 only during its single active cycle |
| 0x04 | RING | write-only; ones raise the peer's doorbells; reads as 0 |
| 0x08 | ACK | write-only; ones clear this side's incoming raw bits; reads as 0 |
| 0x0C | MASK | read/write; ones mask this side's incoming doorbells |
| 0x10 | RAW | read-only; this side's incoming raw status |
| 0x14 | PEND | read-only; raw AND NOT mask, within the window |
| SHARED_BASE + 4*n | MSG[n] | read/write from both ports |

Top module: `mbx_mailbox`

## Requirements
- R1: After hardware reset, both irq outputs are low. Each side's MASK reads back as all ones in that side's window and zero outside it. RAW is zero, and every message word is zero.
- R2: When one side writes RING, each one bit inside the peer's window sets the matching peer RAW bit. Zero bits, and bits outside the window, have no effect.
- R3: When a side writes ACK, each one bit clears the matching bit of that side's RAW. Zero bits leave RAW unchanged.
- R4: A MASK bit set to one stops its doorbell from driving the interrupt, but the RAW bit still latches. PEND reads RAW AND NOT MASK, limited to the window. MASK bits written outside the window read back as zero.
- R5: Each irq output is a register holding the OR of that side's PEND bits. It rises or falls on the clock edge after the edge where PEND changes.
- R6: If a RING bit and an ACK bit hit the same RAW bit in the same cycle, the bit ends up set.
- R7: Message word n sits at byte address SHARED_BASE + 4*n (default base 0x40, 8 words). A value written through either port can be read back through either port. Addresses past the last word, and addresses whose low two bits are not zero, read as 0 and ignore writes.
- R8: If both ports write the same message word in the same cycle, port A's data is kept. A read in the same cycle as a write to the same word returns the old value.
- R9: Writing 1 to CTRL bit 0 from either port raises the reset bit for one cycle, and a read in that cycle returns 1. At the end of that cycle every mailbox register returns to its R1 state. Writing 0 to bit 0 changes nothing.
- R10: The window toward B starts at bit SHIFT_TO_B (default 16). The window toward A starts at bit SHIFT_TO_A (default 0).
- R11: Read data appears on the port's rdata in the cycle after the read request and holds until the next read on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| a_sel | input | 1 | side A access request |
| a_wr | input | 1 | side A write (1) or read (0) |
| a_addr | input | ADDR_W | side A byte address |
| a_wdata | input | 32 | side A write data |
| a_rdata | output | 32 | side A read data, one cycle after the request |
| b_sel | input | 1 | side B access request |
| b_wr | input | 1 | side B write (1) or read (0) |
| b_addr | input | ADDR_W | side B byte address |
| b_wdata | input | 32 | side B write data |
| b_rdata | output | 32 | side B read data, one cycle after the request |
| irq_to_a | output | 1 | interrupt toward side A |
| irq_to_b | output | 1 | interrupt toward side B |

## Verification
The hardest situations to produce are the same-cycle collisions. They need both ports active on one edge: a ring from one side landing on a bit the other side is acknowledging, two writes to one message word, and a read racing a write to the same word. The bench reaches these with a task that drives both ports on the same falling edge, so both requests are captured at one rising edge. The one-cycle window of the software reset bit is caught by issuing a read directly behind the reset write, with no idle cycle between them.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W = 32;
  localparam int DB_W   = 16;

  // word offsets of the per-port control registers
  localparam int W_CTRL = 0;
  localparam int W_RING = 1;
  localparam int W_ACK  = 2;
  localparam int W_MASK = 3;
  localparam int W_RAW  = 4;
  localparam int W_PEND = 5;

  typedef struct packed {
    logic ctrl_wr;
    logic ring_wr;
    logic ack_wr;
    logic mask_wr;
    logic sh_wr;
  } wr_strb_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTRL,
    RD_MASK,
    RD_RAW,
    RD_PEND,
    RD_SHARED
  } rd_sel_e;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int N_SHARED    = 8,
  parameter int SHARED_BASE = 64,
  parameter int SH_IDX_W    = 3
) (
  input  logic                sel,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  output wr_strb_t            strb,
  output rd_sel_e             rd_sel,
  output logic                rd_en,
  output logic [SH_IDX_W-1:0] sh_idx
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] SH_LO = WORD_W'(SHARED_BASE / 4);
  localparam logic [WORD_W-1:0] SH_HI = WORD_W'(SHARED_BASE / 4 + N_SHARED);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] sh_off;
  logic              aligned;
  logic              sh_hit;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign sh_off  = word - SH_LO;
  assign sh_hit  = aligned && (word >= SH_LO) && (word < SH_HI);
  assign sh_idx  = sh_off[SH_IDX_W-1:0];
  assign rd_en   = sel && !wr;

  always_comb begin
    strb   = '0;
    rd_sel = RD_NONE;
    if (sh_hit) begin
      strb.sh_wr = sel && wr;
      rd_sel     = RD_SHARED;
    end else if (aligned) begin
      case (word)
        WORD_W'(W_CTRL): begin strb.ctrl_wr = sel && wr; rd_sel = RD_CTRL; end
        WORD_W'(W_RING): strb.ring_wr = sel && wr;
        WORD_W'(W_ACK):  strb.ack_wr  = sel && wr;
        WORD_W'(W_MASK): begin strb.mask_wr = sel && wr; rd_sel = RD_MASK; end
        WORD_W'(W_RAW):  rd_sel = RD_RAW;
        WORD_W'(W_PEND): rd_sel = RD_PEND;
        default:         rd_sel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int SHIFT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swrst,
  input  logic              gen_en,
  input  logic [DATA_W-1:0] gen_data,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_data,
  input  logic              mask_en,
  input  logic [DATA_W-1:0] mask_data,
  output logic [DATA_W-1:0] raw_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] pend_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] FIELD = DATA_W'({DB_W{1'b1}}) << SHIFT;

  logic [DATA_W-1:0] raw_q, raw_d;
  logic [DATA_W-1:0] mask_q, mask_d;
  logic              irq_q, irq_d;
  logic [DATA_W-1:0] pend;

  assign pend = raw_q & ~mask_q & FIELD;

  always_comb begin
    raw_d = raw_q;
    if (clr_en) raw_d = raw_d & ~clr_data;
    if (gen_en) raw_d = raw_d | gen_data;   // ring after ack: ring wins
    raw_d  = raw_d & FIELD;
    mask_d = mask_en ? (mask_data & FIELD) : mask_q;
    irq_d  = |pend;
    if (swrst) begin
      raw_d  = '0;
      mask_d = FIELD;
      irq_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= FIELD;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      irq_q  <= irq_d;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign pend_o = pend;
  assign irq_o  = irq_q;

  // R6
  gen_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && !swrst) |=> ((raw_q & $past(gen_data) & FIELD) == ($past(gen_data) & FIELD)));
  // R3
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !gen_en && !swrst) |=> ((raw_q & $past(clr_data)) == '0));
  // R5
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swrst |=> (irq_q == |$past(pend)));
  // R9
  swrst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> (raw_q == '0 && mask_q == FIELD && !irq_q));
endmodule

// File: rtl/mbx_shared_bank.sv
module mbx_shared_bank
  import mbx_pkg::*;
#(
  parameter int N_SHARED = 8,
  parameter int SH_IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                swrst,
  input  logic                wr_a,
  input  logic [SH_IDX_W-1:0] idx_a,
  input  logic [DATA_W-1:0]   data_a,
  input  logic                wr_b,
  input  logic [SH_IDX_W-1:0] idx_b,
  input  logic [DATA_W-1:0]   data_b,
  output logic [DATA_W-1:0]   rd_a,
  output logic [DATA_W-1:0]   rd_b
);
  logic [DATA_W-1:0] mem_q [N_SHARED];
  logic [DATA_W-1:0] mem_d [N_SHARED];

  genvar n;
  generate
    for (n = 0; n < N_SHARED; n++) begin : g_word
      always_comb begin
        mem_d[n] = mem_q[n];
        if (wr_b && idx_b == SH_IDX_W'(n)) mem_d[n] = data_b;
        if (wr_a && idx_a == SH_IDX_W'(n)) mem_d[n] = data_a;  // A has priority
        if (swrst) mem_d[n] = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q[n] <= '0;
        else        mem_q[n] <= mem_d[n];
      end
    end
  endgenerate

  assign rd_a = mem_q[idx_a];
  assign rd_b = mem_q[idx_b];

  // R8
  a_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && wr_b && idx_a == idx_b && !swrst) |=> (mem_q[$past(idx_a)] == $past(data_a)));
  // R7
  b_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && !(wr_a && idx_a == idx_b) && !swrst) |=> (mem_q[$past(idx_b)] == $past(data_b)));
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int N_SHARED    = 8,
  parameter int SHARED_BASE = 64,
  parameter int SHIFT_TO_A  = 0,
  parameter int SHIFT_TO_B  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_sel,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [31:0]       a_wdata,
  output logic [31:0]       a_rdata,
  input  logic              b_sel,
  input  logic              b_wr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [31:0]       b_wdata,
  output logic [31:0]       b_rdata,
  output logic              irq_to_a,
  output logic              irq_to_b
);
  localparam int SH_IDX_W = (N_SHARED > 1) ? $clog2(N_SHARED) : 1;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // index 0 = side A, index 1 = side B
  logic              p_sel   [2];
  logic              p_wr    [2];
  logic [ADDR_W-1:0] p_addr  [2];
  logic [DATA_W-1:0] p_wdata [2];
  wr_strb_t          strb    [2];
  rd_sel_e           rd_sel  [2];
  logic              rd_en   [2];
  logic [SH_IDX_W-1:0] sh_idx [2];
  logic [DATA_W-1:0] sh_rd   [2];
  logic [DATA_W-1:0] raw     [2];
  logic [DATA_W-1:0] mask    [2];
  logic [DATA_W-1:0] pend    [2];
  logic              irq     [2];
  logic [DATA_W-1:0] rd_val  [2];
  logic [DATA_W-1:0] rdata_q [2];

  assign p_sel[0]   = a_sel;   assign p_sel[1]   = b_sel;
  assign p_wr[0]    = a_wr;    assign p_wr[1]    = b_wr;
  assign p_addr[0]  = a_addr;  assign p_addr[1]  = b_addr;
  assign p_wdata[0] = a_wdata; assign p_wdata[1] = b_wdata;

  // software reset: one-cycle pulse
  logic swrst_q, swrst_d;
  assign swrst_d = (strb[0].ctrl_wr && p_wdata[0][0]) || (strb[1].ctrl_wr && p_wdata[1][0]);
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) swrst_q <= 1'b0;
    else             swrst_q <= swrst_d;
  end

  genvar p;
  generate
    for (p = 0; p < 2; p++) begin : g_port
      mbx_port_decode #(
        .ADDR_W(ADDR_W), .N_SHARED(N_SHARED),
        .SHARED_BASE(SHARED_BASE), .SH_IDX_W(SH_IDX_W)
      ) u_dec (
        .sel(p_sel[p]), .wr(p_wr[p]), .addr(p_addr[p]),
        .strb(strb[p]), .rd_sel(rd_sel[p]), .rd_en(rd_en[p]), .sh_idx(sh_idx[p])
      );

      // doorbells received by side p, rung by the other side
      mbx_doorbell #(.SHIFT((p == 0) ? SHIFT_TO_A : SHIFT_TO_B)) u_db (
        .clk(clk), .rst_n(rst_sync_n), .swrst(swrst_q),
        .gen_en(strb[1-p].ring_wr), .gen_data(p_wdata[1-p]),
        .clr_en(strb[p].ack_wr),    .clr_data(p_wdata[p]),
        .mask_en(strb[p].mask_wr),  .mask_data(p_wdata[p]),
        .raw_o(raw[p]), .mask_o(mask[p]), .pend_o(pend[p]), .irq_o(irq[p])
      );

      always_comb begin
        case (rd_sel[p])
          RD_CTRL:   rd_val[p] = {{(DATA_W-1){1'b0}}, swrst_q};
          RD_MASK:   rd_val[p] = mask[p];
          RD_RAW:    rd_val[p] = raw[p];
          RD_PEND:   rd_val[p] = pend[p];
          RD_SHARED: rd_val[p] = sh_rd[p];
          default:   rd_val[p] = '0;
        endcase
      end

      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n)    rdata_q[p] <= '0;
        else if (rd_en[p])  rdata_q[p] <= rd_val[p];
      end

      // R11
      rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !rd_en[p] |=> $stable(rdata_q[p]));
    end
  endgenerate

  mbx_shared_bank #(.N_SHARED(N_SHARED), .SH_IDX_W(SH_IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .swrst(swrst_q),
    .wr_a(strb[0].sh_wr), .idx_a(sh_idx[0]), .data_a(p_wdata[0]),
    .wr_b(strb[1].sh_wr), .idx_b(sh_idx[1]), .data_b(p_wdata[1]),
    .rd_a(sh_rd[0]), .rd_b(sh_rd[1])
  );

  assign a_rdata  = rdata_q[0];
  assign b_rdata  = rdata_q[1];
  assign irq_to_a = irq[0];
  assign irq_to_b = irq[1];

  // R9
  swrst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (swrst_q && !swrst_d) |=> !swrst_q);
endmodule

// File: tb/mbx_mailbox_tb.sv
module mbx_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_sel, a_wr, b_sel, b_wr;
  logic [7:0]  a_addr, b_addr;
  logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic        irq_to_a, irq_to_b;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mbx_mailbox u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .irq_to_a(irq_to_a), .irq_to_b(irq_to_b)
  );

  typedef struct packed {
    logic        port;  // 0 = A, 1 = B
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'h0C, 32'h0,        32'hFFFF0000, 4'd1},   // R1 B mask
    '{1'b0, 1'b0, 8'h0C, 32'h0,        32'h0000FFFF, 4'd1},   // R1 A mask
    '{1'b0, 1'b1, 8'h04, 32'h00050000, 32'h0,        4'd2},
    '{1'b1, 1'b0, 8'h10, 32'h0,        32'h00050000, 4'd2},   // R2
    '{1'b0, 1'b1, 8'h04, 32'h00030001, 32'h0,        4'd2},
    '{1'b1, 1'b0, 8'h10, 32'h0,        32'h00070000, 4'd2},   // R2 out-of-window bit dropped
    '{1'b1, 1'b0, 8'h14, 32'h0,        32'h00000000, 4'd4},   // R4 all masked
    '{1'b1, 1'b1, 8'h0C, 32'hFFFEFFFF, 32'h0,        4'd4},
    '{1'b1, 1'b0, 8'h0C, 32'h0,        32'hFFFE0000, 4'd4},   // R4 mask window only
    '{1'b1, 1'b0, 8'h14, 32'h0,        32'h00010000, 4'd4},   // R4 pend
    '{1'b1, 1'b1, 8'h08, 32'h00010000, 32'h0,        4'd3},
    '{1'b1, 1'b0, 8'h10, 32'h0,        32'h00060000, 4'd3},   // R3 zero bits keep
    '{1'b1, 1'b0, 8'h14, 32'h0,        32'h00000000, 4'd3},
    '{1'b1, 1'b1, 8'h08, 32'hFFFFFFFF, 32'h0,        4'd3},
    '{1'b1, 1'b0, 8'h10, 32'h0,        32'h00000000, 4'd3},
    '{1'b1, 1'b1, 8'h04, 32'h00008001, 32'h0,        4'd10},
    '{1'b0, 1'b0, 8'h10, 32'h0,        32'h00008001, 4'd10},  // R10 window toward A
    '{1'b0, 1'b1, 8'h40, 32'hDEADBEEF, 32'h0,        4'd7},
    '{1'b1, 1'b0, 8'h40, 32'h0,        32'hDEADBEEF, 4'd7},   // R7
    '{1'b1, 1'b1, 8'h5C, 32'h12345678, 32'h0,        4'd7},
    '{1'b0, 1'b0, 8'h5C, 32'h0,        32'h12345678, 4'd7},   // R7 last word
    '{1'b0, 1'b1, 8'h60, 32'hFFFFFFFF, 32'h0,        4'd7},
    '{1'b0, 1'b0, 8'h60, 32'h0,        32'h00000000, 4'd7},   // R7 past end
    '{1'b0, 1'b0, 8'h04, 32'h0,        32'h00000000, 4'd2}    // R2 RING reads 0
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic idle_ports();
    a_sel = 1'b0; a_wr = 1'b0; a_addr = '0; a_wdata = '0;
    b_sel = 1'b0; b_wr = 1'b0; b_addr = '0; b_wdata = '0;
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic access(input logic port, input logic wr, input logic [7:0] addr, input logic [31:0] wd);
    if (!port) begin a_sel = 1'b1; a_wr = wr; a_addr = addr; a_wdata = wd; end
    else       begin b_sel = 1'b1; b_wr = wr; b_addr = addr; b_wdata = wd; end
    @(posedge clk);
    @(negedge clk);
    idle_ports();
  endtask

  task automatic dual(input logic aw, input logic [7:0] aa, input logic [31:0] ad,
                      input logic bw, input logic [7:0] ba, input logic [31:0] bd);
    a_sel = 1'b1; a_wr = aw; a_addr = aa; a_wdata = ad;
    b_sel = 1'b1; b_wr = bw; b_addr = ba; b_wdata = bd;
    @(posedge clk);
    @(negedge clk);
    idle_ports();
  endtask

  task automatic rd_chk(input logic port, input logic [7:0] addr, input logic [31:0] exp, input string req);
    logic [31:0] got;
    access(port, 1'b0, addr, 32'h0);
    got = port ? b_rdata : a_rdata;
    chk(got == exp, req, got, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold;
    idle_ports();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state at the outputs
    chk(!irq_to_a && !irq_to_b, "R1", {30'b0, irq_to_a, irq_to_b}, 32'h0);
    chk(a_rdata == 0 && b_rdata == 0, "R1", a_rdata | b_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].port, VECS[i].wr, VECS[i].addr, VECS[i].wdata);
      if (!VECS[i].wr) begin
        logic [31:0] got;
        got = VECS[i].port ? b_rdata : a_rdata;
        chk(got == VECS[i].exp, $sformatf("R%0d", VECS[i].req), got, VECS[i].exp);
      end
    end
    // R4 masked doorbells toward A keep irq low
    chk(!irq_to_a, "R4", {31'b0, irq_to_a}, 32'h0);

    // R5 irq rises one edge after pend
    access(1'b0, 1'b1, 8'h04, 32'h00010000);
    chk(!irq_to_b, "R5", {31'b0, irq_to_b}, 32'h0);
    @(negedge clk);
    chk(irq_to_b, "R5", {31'b0, irq_to_b}, 32'h1);

    // R4 masking drops the line, raw still latched
    access(1'b1, 1'b1, 8'h0C, 32'hFFFFFFFF);
    @(negedge clk);
    chk(!irq_to_b, "R4", {31'b0, irq_to_b}, 32'h0);
    rd_chk(1'b1, 8'h10, 32'h00010000, "R4");

    // R6 ring and ack on the same bit in one cycle
    dual(1'b1, 8'h04, 32'h00020000, 1'b1, 8'h08, 32'h00030000);
    rd_chk(1'b1, 8'h10, 32'h00020000, "R6");

    // R8 simultaneous writes, A wins
    dual(1'b1, 8'h44, 32'hAAAA5555, 1'b1, 8'h44, 32'hBBBB6666);
    rd_chk(1'b1, 8'h44, 32'hAAAA5555, "R8");

    // R8 read racing a write sees the old value
    dual(1'b1, 8'h48, 32'hCAFEF00D, 1'b0, 8'h48, 32'h0);
    chk(b_rdata == 32'h0, "R8", b_rdata, 32'h0);
    rd_chk(1'b0, 8'h48, 32'hCAFEF00D, "R8");

    // R11 rdata holds across idle cycles
    hold = a_rdata;
    repeat (2) @(negedge clk);
    chk(a_rdata == hold, "R11", a_rdata, hold);

    // R9 writing zero to the reset bit changes nothing
    access(1'b0, 1'b1, 8'h00, 32'hFFFFFFFE);
    rd_chk(1'b0, 8'h40, 32'hDEADBEEF, "R9");

    // R9 software reset from side B
    access(1'b1, 1'b1, 8'h00, 32'h00000001);
    rd_chk(1'b0, 8'h00, 32'h00000001, "R9");
    rd_chk(1'b0, 8'h00, 32'h00000000, "R9");
    rd_chk(1'b0, 8'h40, 32'h00000000, "R9");
    rd_chk(1'b1, 8'h0C, 32'hFFFF0000, "R9");
    rd_chk(1'b1, 8'h10, 32'h00000000, "R9");
    rd_chk(1'b0, 8'h10, 32'h00000000, "R9");
    chk(!irq_to_a && !irq_to_b, "R9", {30'b0, irq_to_a, irq_to_b}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule